// File: doc/BRIEF.md
# Startup Cache Block Screening Controller

This controller runs once after reset. It qualifies the blocks of a cache storage array that is built larger than the capacity the chip advertises. It visits the physical blocks from index 0 upward. For each block it writes every word with all-zeros and reads the block back, then writes every word with all-ones and reads it back. Any word that returns something other than the pattern written marks the whole block as faulty. Passing blocks are enabled and counted. Once the count reaches the good-block target held in a configuration input, the walk stops. Blocks that were never reached stay disabled, even if they are healthy.

The faulty-block map lives in flip-flops inside the controller, not in the array it screens. There are two resets. A cold reset erases the map and forces a full screening. A warm reset keeps a completed map: the controller skips the test and reports done at once with the same enables. A warm reset that arrives before the map is complete starts the screening over. If the array runs out of blocks before the target is met, the controller raises a shortfall flag together with done.

The fault model is a single cell stuck at 0 or stuck at 1. A stuck-at-1 cell shows up under the all-zeros pass and a stuck-at-0 cell under the all-ones pass.

Top module: `cache_screen_ctrl`

## Requirements
- R1: After a cold reset, `done`, `short_flag` and `blk_en` are all low until the screening ends.
- R2: Every word of a block is written and read back with all-zeros and again with all-ones. A single stuck cell of either polarity in any word makes the block fail.
- R3: A block that fails is never enabled.
- R4: Screening stops as soon as the number of passing blocks equals `cfg_target`. Blocks after that point stay disabled, and with `short_flag` low exactly `cfg_target` bits of `blk_en` are set.
- R5: Blocks are screened in ascending order from block 0, and bit i of `blk_en` enables block i. The enabled set is therefore the lowest-indexed passing blocks.
- R6: If every physical block has been screened and the target is still not met, `done` and `short_flag` both rise and every passing block is enabled.
- R7: A target of zero completes without touching the array, with `blk_en` all-zero and `short_flag` low.
- R8: After a warm reset with a completed map, the array is not accessed again and `done` is high on the first cycle after the warm reset is released. `blk_en` and `short_flag` are unchanged, and a new `cfg_target` is ignored.
- R9: A warm reset that arrives before the map is complete restarts the screening from block 0 with the current `cfg_target`.
- R10: A cold reset erases any completed map, and a full screening follows.
- R11: `blk_en` is all-zero while `done` is low and becomes valid in the same cycle that `done` rises. `done` then stays high until a reset.
- R12: Block b, word w is accessed at address b*WORDS+w. Every write carries all-zeros or all-ones, and no access falls outside the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high reset that also erases the map |
| warm_rst | input | 1 | Synchronous active-high reset that keeps a completed map |
| cfg_target | input | CNT_W | Number of good blocks to find; sampled when screening starts |
| mem_en | output | 1 | Array access request |
| mem_we | output | 1 | Write when high, read when low (with `mem_en`) |
| mem_addr | output | ADDR_W | Word address, block*WORDS+word |
| mem_wdata | output | DATA_W | Test pattern written |
| mem_rdata | input | DATA_W | Read data, returned one cycle after a read request |
| blk_en | output | NUM_BLOCKS | Per-block enable map, bit i for block i |
| done | output | 1 | Screening finished, or skipped after a warm reset |
| short_flag | output | 1 | Target could not be met with the physical blocks |

## Verification
The bench drives a fault-free array, then an array with a stuck-at-1 cell in the third word of block 1 and a stuck-at-0 cell in the last word of block 3. Because each fault can only be seen under one of the two patterns, a design that drops either pass, or checks only some words, enables the wrong blocks. Targets below, equal to zero and above the healthy-block count separate early stopping, the immediate finish and the shortfall path. Warm resets given after and during screening separate map retention from restart.

// File: rtl/screen_pkg.sv
package screen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL0,
    ST_READ0,
    ST_FILL1,
    ST_READ1,
    ST_DRAIN,
    ST_DECIDE,
    ST_DONE
  } scr_state_t;

  function automatic logic is_fill(scr_state_t s);
    return (s == ST_FILL0) || (s == ST_FILL1);
  endfunction

  function automatic logic is_read(scr_state_t s);
    return (s == ST_READ0) || (s == ST_READ1);
  endfunction

  function automatic logic uses_ones(scr_state_t s);
    return (s == ST_FILL1) || (s == ST_READ1);
  endfunction

endpackage

// File: rtl/screen_walker.sv
module screen_walker #(
  parameter int NUM_BLOCKS = 40,
  parameter int WORDS      = 16,
  parameter int BLK_W      = 6,
  parameter int WORD_W     = 4,
  parameter int ADDR_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              next_blk,
  input  logic              step_word,
  output logic [BLK_W-1:0]  blk_q,
  output logic [WORD_W-1:0] word_q,
  output logic              last_word,
  output logic              last_blk,
  output logic [ADDR_W-1:0] addr
);

  assign last_word = (word_q == WORD_W'(WORDS - 1));
  assign last_blk  = (blk_q == BLK_W'(NUM_BLOCKS - 1));
  assign addr      = ADDR_W'(blk_q) * ADDR_W'(WORDS) + ADDR_W'(word_q);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      blk_q  <= '0;
      word_q <= '0;
    end else if (next_blk) begin
      blk_q  <= blk_q + 1'b1;
      word_q <= '0;
    end else if (step_word) begin
      word_q <= last_word ? '0 : word_q + 1'b1;
    end
  end

endmodule

// File: rtl/screen_compare.sv
module screen_compare #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_fail,
  input  logic              issue_rd,
  input  logic              exp_ones,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail_q
);

  logic              pend_q;
  logic              ones_q;
  logic [DATA_W-1:0] expect_w;
  logic              mismatch;

  assign expect_w = ones_q ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  assign mismatch = pend_q && (rdata != expect_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ones_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      pend_q <= issue_rd;
      ones_q <= exp_ones;
      if (clr_fail) fail_q <= 1'b0;
      else          fail_q <= fail_q | mismatch;
    end
  end

endmodule

// File: rtl/screen_map.sv
module screen_map #(
  parameter int NUM_BLOCKS = 40,
  parameter int BLK_W      = 6
) (
  input  logic                  clk,
  input  logic                  cold_rst,
  input  logic                  clr,
  input  logic                  set_en,
  input  logic [BLK_W-1:0]      set_idx,
  input  logic                  commit,
  input  logic                  short_in,
  output logic [NUM_BLOCKS-1:0] map_q,
  output logic                  valid_q,
  output logic                  short_q
);

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      map_q   <= '0;
      valid_q <= 1'b0;
      short_q <= 1'b0;
    end else begin
      if (clr)         map_q <= '0;
      else if (set_en) map_q[set_idx] <= 1'b1;
      if (commit) begin
        valid_q <= 1'b1;
        short_q <= short_in;
      end
    end
  end

endmodule

// File: rtl/cache_screen_ctrl.sv
module cache_screen_ctrl #(
  parameter int NUM_BLOCKS = 40,
  parameter int WORDS      = 16,
  parameter int DATA_W     = 32,
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1),
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int WORD_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W    = $clog2(NUM_BLOCKS * WORDS)
) (
  input  logic                  clk,
  input  logic                  cold_rst,
  input  logic                  warm_rst,
  input  logic [CNT_W-1:0]      cfg_target,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [NUM_BLOCKS-1:0] blk_en,
  output logic                  done,
  output logic                  short_flag
);

  import screen_pkg::*;

  scr_state_t            state_q;
  logic                  rst_any;
  logic [CNT_W-1:0]      tgt_q;
  logic [CNT_W-1:0]      good_q;
  logic [CNT_W-1:0]      good_nxt;
  logic [NUM_BLOCKS-1:0] en_q;
  logic                  done_q;
  logic                  short_q;

  logic [BLK_W-1:0]      blk_idx;
  logic [WORD_W-1:0]     word_idx;
  logic                  last_word;
  logic                  last_blk;
  logic                  fail_q;

  logic [NUM_BLOCKS-1:0] map_q;
  logic                  map_valid;
  logic                  map_short;

  logic                  pass;
  logic                  hit;
  logic                  finish_blk;
  logic                  finish_zero;
  logic                  next_blk;
  logic                  clr_fail;
  logic                  clr_map;
  logic                  set_en;
  logic [NUM_BLOCKS-1:0] map_after;

  assign rst_any = cold_rst | warm_rst;

  // Array port, decoded from the phase
  assign mem_en    = is_fill(state_q) | is_read(state_q);
  assign mem_we    = is_fill(state_q);
  assign mem_wdata = uses_ones(state_q) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

  // Verdict on the block just screened
  assign pass        = !fail_q;
  assign good_nxt    = good_q + CNT_W'(pass);
  assign hit         = pass && (good_nxt == tgt_q);
  assign finish_blk  = (state_q == ST_DECIDE) && (hit || last_blk);
  assign finish_zero = (state_q == ST_IDLE) && !map_valid && (cfg_target == '0);
  assign next_blk    = (state_q == ST_DECIDE) && !finish_blk;
  assign clr_fail    = (state_q == ST_IDLE) || next_blk;
  assign clr_map     = (state_q == ST_IDLE) && !map_valid;
  assign set_en      = (state_q == ST_DECIDE) && pass;
  assign map_after   = map_q | (pass ? (NUM_BLOCKS'(1) << blk_idx) : '0);

  screen_walker #(
    .NUM_BLOCKS(NUM_BLOCKS), .WORDS(WORDS), .BLK_W(BLK_W),
    .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_walk (
    .clk      (clk),
    .rst      (rst_any),
    .restart  (state_q == ST_IDLE),
    .next_blk (next_blk),
    .step_word(mem_en),
    .blk_q    (blk_idx),
    .word_q   (word_idx),
    .last_word(last_word),
    .last_blk (last_blk),
    .addr     (mem_addr)
  );

  screen_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk     (clk),
    .rst     (rst_any),
    .clr_fail(clr_fail),
    .issue_rd(is_read(state_q)),
    .exp_ones(state_q == ST_READ1),
    .rdata   (mem_rdata),
    .fail_q  (fail_q)
  );

  screen_map #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_map (
    .clk     (clk),
    .cold_rst(cold_rst),
    .clr     (clr_map),
    .set_en  (set_en),
    .set_idx (blk_idx),
    .commit  (finish_blk || finish_zero),
    .short_in(finish_blk && !hit),
    .map_q   (map_q),
    .valid_q (map_valid),
    .short_q (map_short)
  );

  // Target survives a warm reset so a retained map keeps its meaning
  always_ff @(posedge clk) begin
    if (cold_rst)
      tgt_q <= '0;
    else if ((state_q == ST_IDLE) && !map_valid && !warm_rst)
      tgt_q <= cfg_target;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      short_q <= 1'b0;
      en_q    <= '0;
      good_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          good_q <= '0;
          if (map_valid) begin
            done_q  <= 1'b1;
            short_q <= map_short;
            en_q    <= map_q;
            state_q <= ST_DONE;
          end else if (finish_zero) begin
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_FILL0;
          end
        end
        ST_FILL0:  if (last_word) state_q <= ST_READ0;
        ST_READ0:  if (last_word) state_q <= ST_FILL1;
        ST_FILL1:  if (last_word) state_q <= ST_READ1;
        ST_READ1:  if (last_word) state_q <= ST_DRAIN;
        ST_DRAIN:  state_q <= ST_DECIDE;
        ST_DECIDE: begin
          good_q <= good_nxt;
          if (finish_blk) begin
            done_q  <= 1'b1;
            short_q <= !hit;
            en_q    <= map_after;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_FILL0;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign blk_en     = en_q;
  assign done       = done_q;
  assign short_flag = short_q;

endmodule

// File: rtl/screen_ctrl_checker.sv
module screen_ctrl_checker #(
  parameter int NUM_BLOCKS = 40,
  parameter int WORDS      = 16,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 6,
  parameter int ADDR_W     = 10
) (
  input logic                  clk,
  input logic                  cold_rst,
  input logic                  warm_rst,
  input logic                  mem_en,
  input logic                  mem_we,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [DATA_W-1:0]     mem_wdata,
  input logic [NUM_BLOCKS-1:0] blk_en,
  input logic                  done,
  input logic                  short_flag,
  input logic [CNT_W-1:0]      tgt_q,
  input logic                  map_valid
);

  assert_map_hidden_R11: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    !done |-> (blk_en == '0));

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    done |=> done);

  assert_short_with_done_R6: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    short_flag |-> done);

  assert_pattern_R12: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    (mem_en && mem_we) |-> ((mem_wdata == '0) || (mem_wdata == '1)));

  assert_addr_range_R12: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    mem_en |-> (int'(mem_addr) < NUM_BLOCKS * WORDS));

  assert_good_count_R4: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    (done && !short_flag) |-> ($countones(blk_en) == int'(tgt_q)));

  assert_fast_skip_R8: assert property (@(posedge clk) disable iff (cold_rst || warm_rst)
    (map_valid && $past(warm_rst)) |=> done);

  assert_no_retest_R8: assert property (@(posedge clk) disable iff (cold_rst)
    map_valid |-> !mem_en);

endmodule

bind cache_screen_ctrl screen_ctrl_checker #(
  .NUM_BLOCKS(NUM_BLOCKS), .WORDS(WORDS), .DATA_W(DATA_W),
  .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .cold_rst  (cold_rst),
  .warm_rst  (warm_rst),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .blk_en    (blk_en),
  .done      (done),
  .short_flag(short_flag),
  .tgt_q     (tgt_q),
  .map_valid (map_valid)
);

// File: tb/tb_cache_screen_ctrl.sv
`timescale 1ns/1ps
module tb_cache_screen_ctrl;

  localparam int NB  = 8;
  localparam int WPB = 4;
  localparam int DW  = 8;
  localparam int CW  = $clog2(NB + 1);
  localparam int AW  = $clog2(NB * WPB);

  logic          clk = 1'b0;
  logic          cold_rst = 1'b0;
  logic          warm_rst = 1'b0;
  logic [CW-1:0] cfg_target = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [NB-1:0] blk_en;
  logic          done, short_flag;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  int bad_wr = 0;
  bit finished = 0;

  logic [DW-1:0] mem_arr [NB*WPB];
  logic [DW-1:0] stuck0  [NB*WPB];
  logic [DW-1:0] stuck1  [NB*WPB];

  always #2.5 clk = ~clk;

  cache_screen_ctrl #(.NUM_BLOCKS(NB), .WORDS(WPB), .DATA_W(DW)) dut (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .cfg_target(cfg_target),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .blk_en(blk_en), .done(done), .short_flag(short_flag)
  );

  // Array model with stuck cells
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem_arr[mem_addr] <= (mem_wdata & ~stuck0[mem_addr]) | stuck1[mem_addr];
        wr_cnt <= wr_cnt + 1;
        if (!(mem_wdata == '0 || mem_wdata == '1) || int'(mem_addr) >= NB*WPB)
          bad_wr <= bad_wr + 1;
      end else begin
        mem_rdata <= mem_arr[mem_addr];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic cold_start(input int tgt);
    @(negedge clk);
    cfg_target = CW'(tgt);
    cold_rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cold_rst = 1'b0;
  endtask

  // Waits for done; flags any visible map before done (R11)
  task automatic wait_done(input string req);
    int  n = 0;
    bit  leak = 0;
    while (!done && n < 5000) begin
      if (blk_en !== '0 || short_flag !== 1'b0) leak = 1;
      @(negedge clk);
      n++;
    end
    chk(req, {31'd0, done}, 32'd1, "done reached");
    chk("R11", {31'd0, leak}, 32'd0, "map hidden before done");
  endtask

  task automatic t_reset_and_clean();
    cold_start(5);
    chk("R1", {31'd0, done}, 32'd0, "done after cold reset");
    chk("R1", {24'd0, blk_en}, 32'd0, "blk_en after cold reset");
    chk("R1", {31'd0, short_flag}, 32'd0, "short after cold reset");
    wait_done("R4");
    chk("R4", {24'd0, blk_en}, 32'h1F, "clean array target 5");
    chk("R4", {31'd0, short_flag}, 32'd0, "no shortfall");
    repeat (5) @(negedge clk);
    chk("R11", {31'd0, done}, 32'd1, "done holds");
  endtask

  task automatic t_faults();
    stuck1[1*WPB + 2] = 8'h08;   // block 1, word 2, stuck-at-1
    stuck0[3*WPB + 3] = 8'h80;   // block 3, word 3, stuck-at-0
    cold_start(4);
    wait_done("R2");
    chk("R2", {24'd0, blk_en}, 32'h35, "both fault polarities caught");
    chk("R3", {31'd0, blk_en[1] | blk_en[3]}, 32'd0, "faulty blocks disabled");
    chk("R5", {30'd0, blk_en[7:6]}, 32'd0, "blocks past target disabled");
  endtask

  task automatic t_warm_keep();
    int w0;
    @(negedge clk);
    cfg_target = CW'(2);
    warm_rst = 1'b1;
    @(negedge clk);
    w0 = wr_cnt;
    warm_rst = 1'b0;
    @(negedge clk);
    chk("R8", {31'd0, done}, 32'd1, "done one cycle after warm release");
    chk("R8", {24'd0, blk_en}, 32'h35, "map kept, new target ignored");
    repeat (20) @(negedge clk);
    chk("R8", wr_cnt - w0, 32'd0, "no array writes after warm reset");
  endtask

  task automatic t_short();
    cold_start(8);
    @(negedge clk);
    chk("R10", {31'd0, done}, 32'd0, "cold reset forces rescreen");
    wait_done("R6");
    chk("R6", {24'd0, blk_en}, 32'hF5, "all passing blocks on shortfall");
    chk("R6", {31'd0, short_flag}, 32'd1, "shortfall flag");
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    @(negedge clk);
    chk("R8", {31'd0, short_flag}, 32'd1, "shortfall kept over warm reset");
    chk("R8", {24'd0, blk_en}, 32'hF5, "map kept over warm reset");
  endtask

  task automatic t_zero();
    int w0;
    w0 = wr_cnt;
    cold_start(0);
    @(negedge clk);
    chk("R7", {31'd0, done}, 32'd1, "zero target finishes at once");
    chk("R7", {24'd0, blk_en}, 32'd0, "zero target enables nothing");
    chk("R7", {31'd0, short_flag}, 32'd0, "zero target no shortfall");
    chk("R7", wr_cnt - w0, 32'd0, "zero target no array writes");
  endtask

  task automatic t_warm_mid();
    int w0;
    cold_start(6);
    repeat (20) @(negedge clk);
    chk("R9", {31'd0, done}, 32'd0, "still screening");
    cfg_target = CW'(3);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    w0 = wr_cnt;
    wait_done("R9");
    chk("R9", {24'd0, blk_en}, 32'h15, "restart uses new target");
    chk("R9", {31'd0, (wr_cnt - w0) > 0}, 32'd1, "array rescreened");
    chk("R12", bad_wr, 32'd0, "write patterns and range");
  endtask

  initial begin
    for (int i = 0; i < NB*WPB; i++) begin
      stuck0[i] = '0;
      stuck1[i] = '0;
      mem_arr[i] = '0;
    end
    t_reset_and_clean();
    t_faults();
    t_warm_keep();
    t_short();
    t_zero();
    t_warm_mid();
    finished = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule